// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block gathers 96 level-sensitive interrupt sources into one interrupt line for a processor. The sources are grouped into three banks of 32. Source n belongs to bank n>>5 at bit n&31. Each source is synchronised into a raw status word. A per-source mask bit decides whether an active source can raise the shared interrupt line. The per-bank pending words (raw status with masked bits removed) are also driven out, so neighbouring logic can see which sources are waiting.

Software works the block through a single-cycle 32-bit register port. There are four kinds of register: raw status, mask status, mask set and mask clear. For each kind, the three banks sit at consecutive words. This gives a fixed 48-byte window. Mask bits change only through the set and clear words, each of which acts on the bits written as 1. A source is acknowledged by masking it. The source stays reported in raw status for as long as its input level stays high.

Top module: `lvl_irq_aggregator`

## Requirements
- R1: After reset, every mask bit is 1, raw status is 0, pendOut is 0 and irqOut is 0.
- R2: Reading byte offsets 0x00, 0x04 and 0x08 returns the raw status of banks 0, 1 and 2. Source n appears in bank n>>5 at bit n&31. Writes to these offsets change neither the raw status nor any mask bit.
- R3: Reading offsets 0x0C, 0x10 and 0x14 returns the mask words of banks 0, 1 and 2, where a 1 means masked. A mask bit keeps its value unless a set or clear write targets its bank.
- R4: A write to offset 0x18, 0x1C or 0x20 (banks 0, 1, 2) sets the mask bit for every data bit written as 1. Bits written as 0 keep their mask value.
- R5: A write to offset 0x24, 0x28 or 0x2C (banks 0, 1, 2) clears the mask bit for every data bit written as 1. Bits written as 0 keep their mask value.
- R6: pendOut bit n equals raw status bit n AND NOT mask bit n, for all 96 sources.
- R7: irqOut is registered. It is 1 in the cycle after any pendOut bit is 1, and 0 in the cycle after all pendOut bits are 0.
- R8: A change on a source input appears in raw status and pendOut after the third rising clock edge. It appears on irqOut after the fourth.
- R9: Reading a set offset or a clear offset returns the current mask word of that bank.
- R10: An access outside 0x00–0x2F, or at an address whose two low bits are not 00, reads as 0. A write to such an address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | 96 | Level interrupt sources, bit n is source n |
| busAddr | input | 6 | Byte address of the register access |
| busWe | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pendOut | output | 96 | Unmasked active sources, bit n is source n |
| irqOut | output | 1 | Registered OR of all pending bits |

## Verification
The masking path is tried with six source and mask pairs, each table entry followed by readback of every bank register:
- All quiet, which shows no spurious interrupt.
- A single low source fully unmasked, which proves the basic path.
- The top source with every source masked, which shows the mask suppresses the line.
- Every source active with one unmask at a bank edge bit, which catches off-by-one bit placement.
- A source in bank 2 while only bank 1 is unmasked, which separates the banks.
- Mixed bit patterns, which expose any lane swap.

Directed tests then step the synchroniser latency one edge at a time. They also show that set and clear leave the zero-written bits alone, and that misaligned, out-of-window and raw-status writes change nothing.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  // Width of the bank selector carried between control and datapath.
  localparam int unsigned BANK_SEL_W = 4;

  // Register kind; the numeric order is the order of the kinds in the map.
  typedef enum logic [1:0] {
    KIND_RAW  = 2'd0,
    KIND_MASK = 2'd1,
    KIND_SET  = 2'd2,
    KIND_CLR  = 2'd3
  } regKind_e;

  typedef struct packed {
    logic                  hit;    // address decodes to a register
    regKind_e              kind;   // which register kind
    logic [BANK_SEL_W-1:0] bank;   // which bank
    logic                  wrSet;  // write-one-to-set strobe
    logic                  wrClr;  // write-one-to-clear strobe
  } busStrobe_t;

endpackage

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strb
);

  localparam int unsigned NUM_KINDS = 4;
  localparam int unsigned WORDS     = NUM_KINDS * NUM_BANKS;
  localparam int unsigned WIDX_W    = ADDR_W - 2;
  localparam logic [WIDX_W:0] WORDS_L = (WIDX_W + 1)'(WORDS);

  logic [WIDX_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  // Kind-major map: word index = kind * NUM_BANKS + bank.
  always_comb begin
    strb = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (aligned && wordIdx == WIDX_W'(k * NUM_BANKS + b)) begin
          strb.hit  = 1'b1;
          strb.kind = regKind_e'(k[1:0]);
          strb.bank = BANK_SEL_W'(b);
        end
      end
    end
    strb.wrSet = strb.hit && busWe && (strb.kind == KIND_SET);
    strb.wrClr = strb.hit && busWe && (strb.kind == KIND_CLR);
  end

  // R10: nothing outside the aligned window may reach the mask state.
  a_r10_no_write_outside : assert property (@(posedge clk) disable iff (!rstN)
    !(({1'b0, wordIdx} < WORDS_L) && aligned) |-> !(strb.wrSet || strb.wrClr));

  // R4 / R5: mask strobes only with a write, and never both at once.
  a_r4_strobe_needs_we : assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> !(strb.wrSet || strb.wrClr));

  a_r5_strobes_exclusive : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSet, strb.wrClr}));

endmodule

// File: rtl/lvl_irq_datapath.sv
module lvl_irq_datapath
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] srcIn,
  input  busStrobe_t                  strb,
  input  logic [BANK_W-1:0]           wdata,
  output logic [BANK_W-1:0]           rdata,
  output logic [NUM_BANKS*BANK_W-1:0] pendOut,
  output logic                        irqOut
);

  localparam int unsigned SRC_W = NUM_BANKS * BANK_W;

  logic [SRC_W-1:0] syncA;
  logic [SRC_W-1:0] syncB;
  logic [SRC_W-1:0] rawQ;
  logic [SRC_W-1:0] maskQ;
  logic [SRC_W-1:0] pendAll;
  logic             irqQ;

  // Two synchroniser stages, then the status register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      rawQ  <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      rawQ  <= syncB;
    end
  end

  // Mask state: all sources masked out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strb.wrSet && strb.bank == BANK_SEL_W'(b)) begin
          maskQ[b*BANK_W +: BANK_W] <= maskQ[b*BANK_W +: BANK_W] | wdata;
        end else if (strb.wrClr && strb.bank == BANK_SEL_W'(b)) begin
          maskQ[b*BANK_W +: BANK_W] <= maskQ[b*BANK_W +: BANK_W] & ~wdata;
        end
      end
    end
  end

  assign pendAll = rawQ & ~maskQ;
  assign pendOut = pendAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |pendAll;
  end

  assign irqOut = irqQ;

  // Read mux: raw for the raw kind, mask word for every other kind.
  always_comb begin
    rdata = '0;
    if (strb.hit) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strb.bank == BANK_SEL_W'(b)) begin
          if (strb.kind == KIND_RAW) rdata = rawQ[b*BANK_W +: BANK_W];
          else                       rdata = maskQ[b*BANK_W +: BANK_W];
        end
      end
    end
  end

  // R7: the output line follows the pending set one cycle later.
  a_r7_irq_rises : assert property (@(posedge clk) disable iff (!rstN)
    (pendAll != '0) |=> irqOut);

  a_r7_irq_falls : assert property (@(posedge clk) disable iff (!rstN)
    (pendAll == '0) |=> !irqOut);

  // R3: mask is stable without a set or clear strobe.
  a_r3_mask_hold : assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrSet || strb.wrClr) |=> $stable(maskQ));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bankChk
    // R4: every 1 written to a set word ends up masked.
    a_r4_set_bits : assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrSet && strb.bank == BANK_SEL_W'(g)) |=>
      ((maskQ[g*BANK_W +: BANK_W] & $past(wdata)) == $past(wdata)));

    // R5: every 1 written to a clear word ends up unmasked.
    a_r5_clr_bits : assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrClr && strb.bank == BANK_SEL_W'(g)) |=>
      ((maskQ[g*BANK_W +: BANK_W] & $past(wdata)) == '0));
  end

endmodule

// File: rtl/lvl_irq_aggregator.sv
module lvl_irq_aggregator
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] srcIn,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [BANK_W-1:0]           busWdata,
  output logic [BANK_W-1:0]           busRdata,
  output logic [NUM_BANKS*BANK_W-1:0] pendOut,
  output logic                        irqOut
);

  busStrobe_t strb;

  lvl_irq_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb)
  );

  lvl_irq_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .strb   (strb),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .pendOut(pendOut),
    .irqOut (irqOut)
  );

endmodule

// File: tb/lvl_irq_aggregator_tb.sv
module lvl_irq_aggregator_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [95:0] srcIn = '0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [95:0] pendOut;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  lvl_irq_aggregator u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .pendOut(pendOut), .irqOut(irqOut)
  );

  localparam int NVEC = 6;
  localparam logic [95:0] VEC_SRC [NVEC] = '{
    96'h0,
    96'h1,
    96'h80000000_00000000_00000000,
    96'hFFFFFFFF_FFFFFFFF_FFFFFFFF,
    96'h00000001_00000000_00000000,
    96'hA5A5A5A5_5A5A5A5A_0F0F0F0F
  };
  localparam logic [95:0] VEC_MSK [NVEC] = '{
    96'h0,
    96'h0,
    96'hFFFFFFFF_FFFFFFFF_FFFFFFFF,
    96'hFFFFFFFF_FFFFFFFF_7FFFFFFF,
    96'hFFFFFFFF_00000000_FFFFFFFF,
    96'h0000FFFF_FFFF0000_F0F0F0F0
  };

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [95:0] expPend;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    for (int b = 0; b < 3; b++) begin
      rd(6'(12 + 4 * b), d); chk("R1 mask after reset", 96'(d), 96'hFFFFFFFF);
      rd(6'(4 * b), d);      chk("R1 raw after reset", 96'(d), 96'h0);
    end
    chk("R1 pendOut after reset", pendOut, 96'h0);
    chk("R1 irqOut after reset", 96'(irqOut), 96'h0);

    // Table: R2 R3 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      srcIn = VEC_SRC[v];
      for (int b = 0; b < 3; b++) begin
        wr(6'(8'h18 + 4 * b), VEC_MSK[v][b*32 +: 32]);
        wr(6'(8'h24 + 4 * b), ~VEC_MSK[v][b*32 +: 32]);
      end
      repeat (5) @(negedge clk);
      expPend = VEC_SRC[v] & ~VEC_MSK[v];
      for (int b = 0; b < 3; b++) begin
        rd(6'(12 + 4 * b), d); chk("R3 mask word", 96'(d), 96'(VEC_MSK[v][b*32 +: 32]));
        rd(6'(4 * b), d);      chk("R2 raw word", 96'(d), 96'(VEC_SRC[v][b*32 +: 32]));
      end
      chk("R6 pendOut", pendOut, expPend);
      chk("R7 irqOut", 96'(irqOut), 96'(|expPend));
    end

    // R4 / R5 / R9 on bank 1
    srcIn = '0;
    wr(6'h28, 32'hFFFFFFFF);
    wr(6'h1C, 32'h000000F0);
    wr(6'h1C, 32'h0000000F);
    rd(6'h10, d); chk("R4 set keeps zero-written bits", 96'(d), 96'hFF);
    wr(6'h28, 32'h0000000C);
    rd(6'h10, d); chk("R5 clear keeps zero-written bits", 96'(d), 96'hF3);
    rd(6'h1C, d); chk("R9 read at set offset", 96'(d), 96'hF3);
    rd(6'h28, d); chk("R9 read at clear offset", 96'(d), 96'hF3);

    // R10 out of window and misaligned
    wr(6'h30, 32'hFFFFFFFF);
    rd(6'h30, d); chk("R10 read outside window", 96'(d), 96'h0);
    wr(6'h29, 32'hFFFFFFFF);
    wr(6'h1D, 32'hFFFFFFFF);
    rd(6'h10, d); chk("R10 misaligned writes ignored", 96'(d), 96'hF3);
    rd(6'h11, d); chk("R10 misaligned read", 96'(d), 96'h0);
    rd(6'h3C, d); chk("R10 top read", 96'(d), 96'h0);

    // R2 write to raw status ignored
    wr(6'h04, 32'hFFFFFFFF);
    rd(6'h04, d); chk("R2 raw write ignored", 96'(d), 96'h0);
    rd(6'h10, d); chk("R2 raw write leaves mask", 96'(d), 96'hF3);

    // R8 latency: unmask everything, then step one source
    for (int b = 0; b < 3; b++) wr(6'(8'h24 + 4 * b), 32'hFFFFFFFF);
    repeat (4) @(negedge clk);
    chk("R8 quiet before step", pendOut, 96'h0);
    @(posedge clk); #2;
    srcIn = 96'h1 << 40;
    repeat (2) @(posedge clk); #2;
    chk("R8 raw not yet after two edges", pendOut, 96'h0);
    @(posedge clk); #2;
    chk("R8 pend after three edges", pendOut, 96'h1 << 40);
    chk("R8 irq still low after three edges", 96'(irqOut), 96'h0);
    @(posedge clk); #2;
    chk("R8 irq after four edges", 96'(irqOut), 96'h1);

    // R7 fall: acknowledge by masking
    wr(6'h1C, 32'h00000100);
    repeat (2) @(negedge clk);
    chk("R7 irq drops after mask", 96'(irqOut), 96'h0);
    chk("R6 pend cleared by mask", pendOut, 96'h0);

    finishRun();
  end

endmodule